// File: doc/BRIEF.md
# Octal-Radix Shared-Format Adder

This block adds or subtracts two 48-bit words that use one number format for both integers and floating-point values. A value is a signed-magnitude integer mantissa of thirteen octal digits, scaled by eight raised to a signed-magnitude exponent. The radix point sits to the right of the mantissa's last digit. No operand is ever normalized. When the exponent is zero, the word reads as a plain signed-magnitude integer, so integer and floating-point sums share a single datapath.

The caller presents both operands, an add/subtract select and a one-cycle strobe. One clock later the unit returns the result word, a one-cycle valid pulse and two flags. One flag reports exponent overflow. The other reports that alignment shifted a nonzero operand away completely.

Word layout, used by every requirement below:

- Bit 47 is spare.
- Bit 46 is the mantissa sign (1 = negative).
- Bit 45 is the exponent sign (1 = negative).
- Bits 44:39 hold the exponent magnitude.
- Bits 38:0 hold the mantissa magnitude.

The value of a word is (−1)^s46 · m · 8^e.

Top module: `orf_adder`

## Requirements
- R1: Bit 47 of either operand has no effect on the result, and bit 47 of the result word is always 0.
- R2: When both operand exponent magnitudes (bits 44:39) are zero, the result is the signed-magnitude integer sum of the mantissas. Its exponent field is zero whenever the magnitude fits in 39 bits.
- R3: When the magnitude of a sum reaches 2^39, the mantissa is shifted right by 3 bits, with truncation, and the exponent is raised by one. An integer-mode overflow therefore yields exponent +1 instead of wrapping.
- R4: When the exponents differ, the operand with the smaller signed exponent has its mantissa shifted right 3 bits per unit of difference. The result takes the larger exponent. No normalization is applied, so leading zero digits are kept.
- R5: If the exponent difference is 13 or more, the smaller operand contributes zero. The underflow flag is 1 exactly when a nonzero mantissa became zero through alignment.
- R6: With the subtract select at 1, the second operand's mantissa sign is inverted before the addition.
- R7: If the aligned operands have equal signs, the result takes that sign. Otherwise it takes the sign of the operand with the larger aligned magnitude.
- R8: A zero result mantissa is output as the all-zero word: positive sign, zero exponent.
- R9: If the result exponent would exceed +63, the overflow flag is 1. The word then saturates to exponent +63 with all mantissa bits set, and the result sign is kept.
- R10: The result, flags and valid are registered one cycle after the strobe. Valid is high for exactly one cycle per strobe, and valid and result are zero after reset.
- R11: An exponent of negative zero is treated as zero, including for selecting integer mode. A zero result exponent is always output with a positive exponent sign.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation strobe |
| in_a | input | 48 | First operand word |
| in_b | input | 48 | Second operand word |
| in_sub | input | 1 | 1 = subtract in_b from in_a |
| out_valid | output | 1 | Result valid, one cycle per strobe |
| out_result | output | 48 | Result word |
| out_ovf | output | 1 | Exponent overflow, result saturated |
| out_unf | output | 1 | A nonzero operand was aligned to zero |

## Verification
The bound checker watches several properties on every cycle:

- the strobe-to-valid timing;
- that the spare bit is never set;
- that zero results are in canonical form;
- the saturated overflow pattern;
- that no result carries a negative-zero exponent;
- that operands with zero exponents never produce a negative exponent, overflow or underflow.

Whether a result has the right value can only be shown by the bench's reference model. This covers:

- alignment by the right number of octal digits;
- the 13-digit cut-off and its underflow flag;
- the choice of sign between operands of unequal magnitude;
- the truncating rescale on carry-out.

The bench drives these through directed corner cases and a long run of random operands with small exponent spreads.

// File: rtl/orf_pkg.sv
// Shared constants, word type and exponent decode for the octal-radix adder.
// Assumes a spare top bit, two sign bits, an exponent magnitude and an
// integer mantissa made of whole octal digits.
package orf_pkg;
    localparam int DIG_W        = 3;
    localparam int MAN_DIGITS   = 13;
    localparam int EXP_W        = 6;
    localparam int MAN_W        = DIG_W * MAN_DIGITS;
    localparam int WORD_W       = MAN_W + EXP_W + 3;
    localparam int EV_W         = EXP_W + 2;
    localparam int EXP_MAX      = (1 << EXP_W) - 1;
    localparam int SHIFT_STAGES = $clog2(MAN_DIGITS);

    typedef struct packed {
        logic             spare;
        logic             msign;
        logic             esign;
        logic [EXP_W-1:0] emag;
        logic [MAN_W-1:0] mmag;
    } oword_t;

    // Turn a sign/magnitude exponent into a two's-complement value.
    function automatic logic signed [EV_W-1:0] exp_value(input logic s, input logic [EXP_W-1:0] m);
        logic signed [EV_W-1:0] v;
        v = $signed({2'b00, m});
        return s ? -v : v;
    endfunction
endpackage

// File: rtl/orf_align.sv
// Exponent compare and octal alignment. The operand with the smaller
// exponent is shifted right by whole digits through a log-depth shifter.
// Assumes exponents lie in -EXP_MAX..EXP_MAX.
module orf_align
    import orf_pkg::*;
(
    input  logic [MAN_W-1:0]        a_mant,
    input  logic [MAN_W-1:0]        b_mant,
    input  logic                    a_sign,
    input  logic                    b_sign,
    input  logic signed [EV_W-1:0]  a_exp,
    input  logic signed [EV_W-1:0]  b_exp,
    output logic [MAN_W-1:0]        big_mant,
    output logic                    big_sign,
    output logic [MAN_W-1:0]        sml_mant,
    output logic                    sml_sign,
    output logic signed [EV_W-1:0]  big_exp,
    output logic                    lost
);
    logic             a_big;
    logic [EV_W-1:0]  diff;
    logic [MAN_W-1:0] raw;
    logic [MAN_W-1:0] stage [SHIFT_STAGES+1];

    // Pick the larger exponent and the distance between the two exponents.
    always_comb begin
        a_big    = (a_exp >= b_exp);
        diff     = a_big ? EV_W'(a_exp - b_exp) : EV_W'(b_exp - a_exp);
        big_mant = a_big ? a_mant : b_mant;
        big_sign = a_big ? a_sign : b_sign;
        big_exp  = a_big ? a_exp  : b_exp;
        raw      = a_big ? b_mant : a_mant;
        sml_sign = a_big ? b_sign : a_sign;
    end

    assign stage[0] = raw;

    // One stage per bit of the digit distance, each stage moving 2^k digits.
    generate
        for (genvar k = 0; k < SHIFT_STAGES; k++) begin : g_shift
            assign stage[k+1] = diff[k] ? (stage[k] >> (DIG_W * (1 << k))) : stage[k];
        end
    endgenerate

    // Drop the operand completely once it is a full mantissa width away.
    always_comb begin
        sml_mant = (diff >= EV_W'(MAN_DIGITS)) ? '0 : stage[SHIFT_STAGES];
        lost     = (raw != '0) && (sml_mant == '0);
    end
endmodule

// File: rtl/orf_smadd.sv
// Signed-magnitude adder for aligned mantissas. The result carries one
// extra bit for carry-out. Assumes both inputs are magnitudes of equal width.
module orf_smadd
    import orf_pkg::*;
(
    input  logic [MAN_W-1:0] big_mant,
    input  logic             big_sign,
    input  logic [MAN_W-1:0] sml_mant,
    input  logic             sml_sign,
    output logic [MAN_W:0]   sum,
    output logic             sum_sign
);
    // Add like signs; for unlike signs, subtract the smaller magnitude from the larger.
    always_comb begin
        if (big_sign == sml_sign) begin
            sum      = {1'b0, big_mant} + {1'b0, sml_mant};
            sum_sign = big_sign;
        end else if (big_mant >= sml_mant) begin
            sum      = {1'b0, big_mant - sml_mant};
            sum_sign = big_sign;
        end else begin
            sum      = {1'b0, sml_mant - big_mant};
            sum_sign = sml_sign;
        end
    end
endmodule

// File: rtl/orf_pack.sv
// Result packing: one-digit rescale on carry-out, overflow saturation and
// canonical zero. Assumes the incoming exponent is at most EXP_MAX.
module orf_pack
    import orf_pkg::*;
(
    input  logic [MAN_W:0]          sum,
    input  logic                    sum_sign,
    input  logic signed [EV_W-1:0]  big_exp,
    output logic [WORD_W-1:0]       word,
    output logic                    ovf
);
    logic                   carry;
    logic [MAN_W-1:0]       mant;
    logic signed [EV_W-1:0] e;
    logic [EV_W-1:0]        e_mag;
    oword_t                 w;

    // Rescale by one digit on carry and build the output fields.
    always_comb begin
        carry = sum[MAN_W];
        mant  = carry ? MAN_W'(sum[MAN_W:DIG_W]) : sum[MAN_W-1:0];
        e     = big_exp + $signed({{(EV_W-1){1'b0}}, carry});
        ovf   = (e > $signed(EV_W'(EXP_MAX)));
        if (e < 0) e_mag = EV_W'(-e);
        else       e_mag = EV_W'(e);
        w = '0;
        if (mant != '0) begin
            w.msign = sum_sign;
            if (ovf) begin
                w.emag = '1;
                w.mmag = '1;
            end else begin
                w.esign = (e < 0);
                w.emag  = e_mag[EXP_W-1:0];
                w.mmag  = mant;
            end
        end
        word = w;
    end
endmodule

// File: rtl/orf_adder.sv
// Top of the octal-radix shared-format adder. Decodes both words, applies
// the subtract select, aligns, adds, packs, and registers the result one
// cycle after the strobe. Assumes callers keep the spare bit for their own use.
module orf_adder
    import orf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    input  logic              in_sub,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_ovf,
    output logic              out_unf
);
    oword_t                 wa, wb;
    logic signed [EV_W-1:0] ea, eb, big_exp;
    logic [MAN_W-1:0]       big_mant, sml_mant;
    logic                   big_sign, sml_sign, lost, sum_sign, ovf;
    logic [MAN_W:0]         sum;
    logic [WORD_W-1:0]      word;

    // Field decode; subtraction flips the second mantissa sign.
    always_comb begin
        wa = oword_t'(in_a);
        wb = oword_t'(in_b);
        ea = exp_value(wa.esign, wa.emag);
        eb = exp_value(wb.esign, wb.emag);
    end

    orf_align u_align (
        .a_mant  (wa.mmag),
        .b_mant  (wb.mmag),
        .a_sign  (wa.msign),
        .b_sign  (wb.msign ^ in_sub),
        .a_exp   (ea),
        .b_exp   (eb),
        .big_mant(big_mant),
        .big_sign(big_sign),
        .sml_mant(sml_mant),
        .sml_sign(sml_sign),
        .big_exp (big_exp),
        .lost    (lost)
    );

    orf_smadd u_add (
        .big_mant(big_mant),
        .big_sign(big_sign),
        .sml_mant(sml_mant),
        .sml_sign(sml_sign),
        .sum     (sum),
        .sum_sign(sum_sign)
    );

    orf_pack u_pack (
        .sum     (sum),
        .sum_sign(sum_sign),
        .big_exp (big_exp),
        .word    (word),
        .ovf     (ovf)
    );

    // Output register: capture on strobe, pulse valid for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_result <= '0;
            out_ovf    <= 1'b0;
            out_unf    <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_result <= word;
                out_ovf    <= ovf;
                out_unf    <= lost;
            end
        end
    end
endmodule

// File: rtl/orf_adder_chk.sv
// Property checker for orf_adder, attached by bind. Observes ports only.
module orf_adder_chk
    import orf_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [WORD_W-1:0] in_a,
    input logic [WORD_W-1:0] in_b,
    input logic              out_valid,
    input logic [WORD_W-1:0] out_result,
    input logic              out_ovf,
    input logic              out_unf
);
    localparam int EMAG_LO = MAN_W;
    localparam int EMAG_HI = MAN_W + EXP_W - 1;
    localparam int ESIGN_B = MAN_W + EXP_W;

    assert_valid_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_spare_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_result[WORD_W-1]);
    assert_zero_canon_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result[MAN_W-1:0] == '0) |-> out_result == '0);
    assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ovf) |-> (out_result[EMAG_HI:EMAG_LO] == '1
                                    && out_result[MAN_W-1:0] == '1
                                    && !out_result[ESIGN_B]));
    assert_exp_pos_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_result[EMAG_HI:EMAG_LO] == '0) |-> !out_result[ESIGN_B]);
    assert_int_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_a[EMAG_HI:EMAG_LO] == '0 && in_b[EMAG_HI:EMAG_LO] == '0)
        |=> (!out_result[ESIGN_B] && out_result[EMAG_HI:EMAG_LO] <= EXP_W'(1)
             && !out_ovf && !out_unf));
endmodule

bind orf_adder orf_adder_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_a      (in_a),
    .in_b      (in_b),
    .out_valid (out_valid),
    .out_result(out_result),
    .out_ovf   (out_ovf),
    .out_unf   (out_unf)
);

// File: tb/tb_orf_adder.sv
`timescale 1ns/1ps
// Bench for orf_adder: a behavioural integer model predicts each result,
// and the outputs are compared on every falling edge.
module tb_orf_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [47:0] in_a = '0, in_b = '0;
    logic        in_sub = 1'b0;
    logic        out_valid, out_ovf, out_unf;
    logic [47:0] out_result;

    int    errors = 0;
    int    checks = 0;
    bit    running = 0;
    string cur_tag = "";

    logic        exp_v = 1'b0;
    logic [49:0] exp_r = '0;
    string       exp_tag = "";

    always #2 clk = ~clk;

    orf_adder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .in_sub(in_sub), .out_valid(out_valid), .out_result(out_result),
        .out_ovf(out_ovf), .out_unf(out_unf)
    );

    function automatic logic [47:0] mk(input logic ms, input int e, input longint m);
        int ae = (e < 0) ? -e : e;
        return {1'b0, ms, (e < 0), 6'(ae), 39'(m)};
    endfunction

    function automatic longint shrink(input longint m, input int d);
        longint r = m;
        if (d >= 13) return 0;
        for (int i = 0; i < d; i++) r = r / 8;
        return r;
    endfunction

    // Value-level model: align by digits, add signed integers, rescale once.
    function automatic logic [49:0] ref_add(input logic [47:0] a, input logic [47:0] b, input logic sub);
        longint ma, mb, va, vb, s, mag;
        int ea, eb, e;
        logic unf, ovf, neg;
        logic [47:0] w;
        ma = longint'(a[38:0]);
        mb = longint'(b[38:0]);
        ea = a[45] ? -int'(a[44:39]) : int'(a[44:39]);
        eb = b[45] ? -int'(b[44:39]) : int'(b[44:39]);
        if (ea >= eb) begin
            e = ea; va = ma; vb = shrink(mb, ea - eb); unf = (mb != 0) && (vb == 0);
        end else begin
            e = eb; vb = mb; va = shrink(ma, eb - ea); unf = (ma != 0) && (va == 0);
        end
        s = (a[46] ? -va : va) + ((b[46] ^ sub) ? -vb : vb);
        neg = (s < 0);
        mag = neg ? -s : s;
        if (mag >= (longint'(1) << 39)) begin
            mag = mag / 8;
            e = e + 1;
        end
        ovf = 1'b0;
        w = '0;
        if (mag != 0) begin
            if (e > 63) begin
                ovf = 1'b1;
                w = {1'b0, neg, 1'b0, 6'd63, {39{1'b1}}};
            end else begin
                w = mk(neg, e, mag);
            end
        end
        return {ovf, unf, w};
    endfunction

    // Prediction register: mirrors the one-cycle latency from the requirements.
    always @(posedge clk) begin
        if (!rst_n) exp_v <= 1'b0;
        else begin
            exp_v <= in_valid;
            if (in_valid) begin
                exp_r   <= ref_add(in_a, in_b, in_sub);
                exp_tag <= cur_tag;
            end
        end
    end

    // Compare on the falling edge, away from the capturing edge.
    always @(negedge clk) begin
        if (rst_n && running) begin
            checks++;
            if (out_valid !== exp_v) begin
                errors++;
                $display("FAIL R10 valid: actual=%0b expected=%0b", out_valid, exp_v);
            end
            if (exp_v) begin
                checks++;
                if ({out_ovf, out_unf, out_result} !== exp_r) begin
                    errors++;
                    $display("FAIL %s: actual ovf=%0b unf=%0b word=%h expected ovf=%0b unf=%0b word=%h",
                             exp_tag, out_ovf, out_unf, out_result, exp_r[49], exp_r[48], exp_r[47:0]);
                end
            end
        end
    end

    task automatic op(input logic [47:0] a, input logic [47:0] b, input logic s, input string tag);
        @(negedge clk);
        in_a = a; in_b = b; in_sub = s; in_valid = 1'b1; cur_tag = tag;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    initial begin
        #800_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_result !== '0) begin
            errors++;
            $display("FAIL R10 reset: actual valid=%0b word=%h expected valid=0 word=0", out_valid, out_result);
        end
        running = 1;

        op(mk(0, 0, 5), mk(0, 0, 3), 0, "R2 int add");
        op(mk(0, 0, 5), mk(1, 0, 9), 0, "R2 mixed signs");
        op(mk(1, 0, 7), mk(1, 0, 8), 0, "R2 both negative");
        idle(1);
        op(mk(0, 0, (longint'(1) << 39) - 1), mk(0, 0, 1), 0, "R3 int carry rescale");
        op(mk(1, 0, (longint'(1) << 39) - 3), mk(1, 0, 12), 0, "R3 negative carry truncation");
        op(mk(0, 2, 1), mk(0, 0, 64), 0, "R4 align two digits");
        op(mk(0, 1, 5), mk(0, 1, 3), 0, "R4 unnormalized kept");
        op(mk(0, -1, 10), mk(0, -3, 640), 0, "R4 negative exponents");
        op(mk(0, 0, 9), mk(0, 3, 2), 0, "R4 second operand larger exponent");
        op(mk(0, 13, 1), mk(0, 0, 7), 0, "R5 thirteen digit cut-off");
        op(mk(0, 12, 1), mk(0, 0, longint'(1) << 38), 0, "R5 twelve digits kept");
        op(mk(0, 4, 0), mk(0, 0, 5), 0, "R5 zero operand lost no flag");
        idle(2);
        op(mk(0, 0, 10), mk(0, 0, 3), 1, "R6 subtract");
        op(mk(0, 0, 3), mk(0, 0, 10), 1, "R6 subtract negative result");
        op(mk(1, 2, 4), mk(1, 2, 9), 1, "R6 subtract negatives");
        op(mk(1, 0, 3), mk(0, 0, 10), 0, "R7 larger magnitude sign");
        op(mk(0, 1, 1), mk(1, 0, 20), 0, "R7 aligned magnitude decides");
        op(mk(0, 5, 4), mk(0, 5, 4), 1, "R8 cancel to zero");
        op(mk(1, 0, 0), mk(0, 0, 0), 0, "R8 negative zero");
        op(mk(1, -7, 3), mk(0, -7, 3), 0, "R8 float cancel");
        op(mk(0, 63, (longint'(1) << 39) - 1), mk(0, 63, (longint'(1) << 39) - 1), 0, "R9 overflow");
        op(mk(1, 63, (longint'(1) << 39) - 1), mk(1, 63, 1), 0, "R9 negative overflow");
        op(mk(0, 63, 5), mk(0, 63, 6), 0, "R9 no overflow at limit");
        op({1'b1, mk(0, 0, 2)} | 48'h8000_0000_0000, mk(0, 0, 3) | 48'h8000_0000_0000, 0, "R1 spare bit ignored");
        op(mk(0, 0, 2) | (48'h1 << 45), mk(0, 0, 3), 0, "R11 negative zero exponent");
        op(mk(0, -1, 8), mk(1, -1, 0) , 0, "R11 result exponent sign");
        op(mk(0, -1, (longint'(1) << 39) - 1), mk(0, -1, 1), 0, "R11 carry to exponent zero");
        idle(3);

        for (int i = 0; i < 400; i++) begin
            logic [47:0] ra, rb;
            ra = mk(1'($urandom), int'($urandom_range(0, 16)) - 8,
                    longint'({$urandom, $urandom} & 64'h7F_FFFF_FFFF) >> $urandom_range(0, 38));
            rb = mk(1'($urandom), int'($urandom_range(0, 16)) - 8,
                    longint'({$urandom, $urandom} & 64'h7F_FFFF_FFFF) >> $urandom_range(0, 38));
            if (($urandom & 7) == 0) ra[47] = 1'b1;
            if (($urandom & 15) == 0) ra[44:39] = 6'd0;
            if (($urandom & 15) == 0) rb[44:39] = 6'd0;
            op(ra, rb, 1'($urandom), "R4 R7 random mix");
            if (($urandom & 3) == 0) idle(1);
        end
        idle(3);

        running = 0;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule